// File: doc/BRIEF.md
# Timer-Watchdog Interrupt Source Router

This block sits between a timer/watchdog counter, an external interrupt pin and an external reset pin on one side, and the reset and interrupt logic of the chip on the other side. It decides which event reaches each of three outputs. The outputs are a system reset pulse, a request on a maskable external-interrupt channel (channel A0) and a top-level non-maskable request. The mode input picks watchdog or plain timer operation. Each of the two request channels has a select bit that picks either the external pin or the internal event.

Each request channel holds a sticky pending flag, and the request output is that flag. Hardware sets the flag when the channel's selected source fires. Software sets and clears it through strobes, and a software set is how a trap is raised. The external pin and the external reset are first passed through a two-stage synchronizer, and only a rising edge of each is used. A reset caused by the watchdog sets a sticky flag. That flag survives the reset pulse it records and is cleared only by software or by the power-on reset.

Top module: `irq_src_router`

## Requirements
- R1: While `por_n` is low, and right after it goes high, `sys_rst_o`, `a0_req_o`, `tl_req_o` and `wdr_flag_o` are all 0.
- R2: In watchdog mode (`timer_mode`=0), a cycle with `eoc_pulse`=1 starts a `sys_rst_o` pulse that is high for exactly RST_CYCLES (default 4) consecutive cycles, and it sets `wdr_flag_o` to 1.
- R3: A rising edge of `ext_rst`, taken after the synchronizer, starts one `sys_rst_o` pulse of RST_CYCLES cycles in either mode and leaves `wdr_flag_o` unchanged. Holding `ext_rst` high gives no further pulse.
- R4: In timer mode (`timer_mode`=1), `eoc_pulse` never causes a `sys_rst_o` pulse.
- R5: When a channel's select bit (`a0_sel_pin` or `tl_sel_pin`) is 1, a synchronized rising edge of `ext_pin` sets that channel's pending flag, in either mode.
- R6: In timer mode, with the select bit at 0, `eoc_pulse` sets the channel's pending flag only while `eoc_irq_en`=1. With `eoc_irq_en`=0 the pulse has no effect on the flag.
- R7: In watchdog mode, with the select bit at 0, `eoc_pulse` never sets that channel's pending flag. Only software can set it.
- R8: In timer mode, with both select bits at 0, an enabled `eoc_pulse` sets only the channel-A0 flag. `tl_req_o` stays 0.
- R9: A set strobe (`a0_pend_set`, `tl_pend_set`) sets its flag in any configuration, and a clear strobe clears it. When both arrive in the same cycle, the flag ends up set.
- R10: `wdr_flag_o` stays 1 through and after the reset pulse. `wdr_flag_clr` clears it. A watchdog event in the same cycle as the clear leaves it set.
- R11: A trigger that arrives while a reset pulse is still running neither extends nor restarts that pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on reset, active low, asynchronous |
| timer_mode | input | 1 | 0 = watchdog mode, 1 = plain timer mode |
| a0_sel_pin | input | 1 | Channel-A0 source: 1 = external pin, 0 = internal event |
| tl_sel_pin | input | 1 | Top-level source: 1 = external pin, 0 = internal event |
| eoc_irq_en | input | 1 | Lets the end-of-count event raise interrupts in timer mode |
| eoc_pulse | input | 1 | One-cycle end-of-count event from the counter |
| ext_pin | input | 1 | External interrupt pin, asynchronous |
| ext_rst | input | 1 | External reset pin, active high, asynchronous |
| a0_pend_set | input | 1 | Software set strobe for the channel-A0 pending flag |
| a0_pend_clr | input | 1 | Software clear strobe for the channel-A0 pending flag |
| tl_pend_set | input | 1 | Software set strobe for the top-level pending flag |
| tl_pend_clr | input | 1 | Software clear strobe for the top-level pending flag |
| wdr_flag_clr | input | 1 | Software clear strobe for the watchdog-reset flag |
| sys_rst_o | output | 1 | System reset pulse |
| a0_req_o | output | 1 | Channel-A0 interrupt request (its pending flag) |
| tl_req_o | output | 1 | Top-level non-maskable request (its pending flag) |
| wdr_flag_o | output | 1 | Sticky flag: the last reset came from the watchdog |

## Verification
Some rules are checked on every cycle. These are that a set strobe beats a clear strobe, that a flag falls after a lone clear, that the reset pulse rises only after a trigger and is never restarted while it runs, that the end-of-count event never resets in timer mode, and that the top-level flag is never set by the end-of-count event in the tie case. Other behaviour can only be shown by the bench's scenarios. The bench sweeps all sixteen combinations of mode, both select bits and the enable, and drives the end-of-count event and the pin in each one. In this way it shows the routing table itself, the exact pulse length, the pin and reset passing through the synchronizer, and the watchdog-reset flag surviving its own reset.

// File: rtl/irq_src_router_pkg.sv
package irq_src_router_pkg;

  // Event that sets a channel's pending flag from hardware.
  function automatic logic chan_hit(input logic sel_pin,
                                    input logic pin_ev,
                                    input logic cnt_ev);
    return sel_pin ? pin_ev : cnt_ev;
  endfunction

  // Count event reaching the top-level channel: it is withheld when
  // channel A0 also takes the count event (A0 has precedence).
  function automatic logic tl_cnt_gate(input logic a0_sel_pin,
                                       input logic cnt_ev);
    return cnt_ev & a0_sel_pin;
  endfunction

  // Width of a down-counter that holds values 0..n.
  function automatic int cnt_width(input int n);
    return (n < 2) ? 1 : $clog2(n + 1);
  endfunction

endpackage

// File: rtl/irr_sync.sv
module irr_sync #(
  parameter int W      = 2,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) stg[i] <= '0;
    end else begin
      stg[0] <= d;
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/irr_flag.sv
module irr_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     q <= 1'b0;
    else if (set_i) q <= 1'b1;
    else if (clr_i) q <= 1'b0;
  end

  // R9 / R10: a set strobe always wins over a clear in the same cycle
  p_set_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
    set_i |=> q);
  // R9 / R10: a lone clear drops the flag
  p_clr_drops_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_i && !set_i) |=> !q);
endmodule

// File: rtl/irr_rst_pulse.sv
module irr_rst_pulse #(
  parameter int CYCLES = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic trig_i,
  output logic active_o
);
  localparam int CW = irq_src_router_pkg::cnt_width(CYCLES);
  localparam logic [CW-1:0] LOAD = CW'(CYCLES);

  logic [CW-1:0] remain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                         remain <= '0;
    else if (remain == '0 && trig_i)    remain <= LOAD;
    else if (remain != '0)              remain <= remain - 1'b1;
  end

  assign active_o = (remain != '0);

  // R2 / R3: a pulse only begins after a trigger
  p_rise_needs_trig_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(active_o) |-> $past(trig_i));
  // R11: a trigger during a running pulse does not reload it
  p_no_restart_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (active_o && trig_i) |=> (remain < $past(remain)));
  // R2: an idle trigger always starts a pulse
  p_idle_trig_starts_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!active_o && trig_i) |=> active_o);
endmodule

// File: rtl/irq_src_router.sv
module irq_src_router #(
  parameter int RST_CYCLES  = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic por_n,
  input  logic timer_mode,
  input  logic a0_sel_pin,
  input  logic tl_sel_pin,
  input  logic eoc_irq_en,
  input  logic eoc_pulse,
  input  logic ext_pin,
  input  logic ext_rst,
  input  logic a0_pend_set,
  input  logic a0_pend_clr,
  input  logic tl_pend_set,
  input  logic tl_pend_clr,
  input  logic wdr_flag_clr,
  output logic sys_rst_o,
  output logic a0_req_o,
  output logic tl_req_o,
  output logic wdr_flag_o
);
  import irq_src_router_pkg::*;

  localparam int NCH = 2;   // channel 0 = A0, channel 1 = top level

  // Synchronize and edge-detect the two asynchronous pins.
  logic [1:0] pins_sync, pins_prev;
  irr_sync #(.W(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(por_n), .d({ext_rst, ext_pin}), .q(pins_sync));

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) pins_prev <= '0;
    else        pins_prev <= pins_sync;
  end

  logic pin_rise, xrst_rise;
  assign pin_rise  = pins_sync[0] & ~pins_prev[0];
  assign xrst_rise = pins_sync[1] & ~pins_prev[1];

  // Internal events, brought out as named wires.
  logic wdg_trig, cnt_irq_ev, rst_trig;
  assign wdg_trig   = ~timer_mode & eoc_pulse;
  assign cnt_irq_ev = timer_mode & eoc_pulse & eoc_irq_en;
  assign rst_trig   = wdg_trig | xrst_rise;

  // Per-channel pending flags.
  logic [NCH-1:0] hw_set, sw_set, sw_clr, pend;
  assign hw_set[0] = chan_hit(a0_sel_pin, pin_rise, cnt_irq_ev);
  assign hw_set[1] = chan_hit(tl_sel_pin, pin_rise,
                              tl_cnt_gate(a0_sel_pin, cnt_irq_ev));
  assign sw_set    = {tl_pend_set, a0_pend_set};
  assign sw_clr    = {tl_pend_clr, a0_pend_clr};

  for (genvar c = 0; c < NCH; c++) begin : g_chan
    irr_flag u_pend (
      .clk(clk), .rst_n(por_n),
      .set_i(hw_set[c] | sw_set[c]), .clr_i(sw_clr[c]), .q(pend[c]));
  end

  assign a0_req_o = pend[0];
  assign tl_req_o = pend[1];

  // Reset pulse and the sticky watchdog-reset flag.
  irr_rst_pulse #(.CYCLES(RST_CYCLES)) u_rst (
    .clk(clk), .rst_n(por_n), .trig_i(rst_trig), .active_o(sys_rst_o));

  irr_flag u_wdr (
    .clk(clk), .rst_n(por_n),
    .set_i(wdg_trig), .clr_i(wdr_flag_clr), .q(wdr_flag_o));

  // R4: in timer mode only the external reset can start a pulse
  p_timer_no_wdg_rst_r4: assert property (@(posedge clk) disable iff (!por_n)
    (timer_mode && !xrst_rise && !sys_rst_o) |=> !sys_rst_o);
  // R8: tie case, count event must not raise the top-level flag
  p_tie_tl_quiet_r8: assert property (@(posedge clk) disable iff (!por_n)
    (timer_mode && !a0_sel_pin && !tl_sel_pin && !tl_pend_set && !tl_req_o)
      |=> !tl_req_o);
  // R7: watchdog mode, count-selected channel only moves on software set
  p_wdg_a0_sw_only_r7: assert property (@(posedge clk) disable iff (!por_n)
    (!timer_mode && !a0_sel_pin && !a0_pend_set && !a0_req_o) |=> !a0_req_o);
  // R2: a watchdog event records itself in the sticky flag
  p_wdg_sets_flag_r2: assert property (@(posedge clk) disable iff (!por_n)
    wdg_trig |=> wdr_flag_o);
  // R3: an external reset alone never sets the sticky flag
  p_xrst_no_flag_r3: assert property (@(posedge clk) disable iff (!por_n)
    (!wdg_trig && !wdr_flag_o) |=> !wdr_flag_o);
endmodule

// File: tb/sim_irq_src_router.sv
`timescale 1ns/1ps
module sim_irq_src_router;
  localparam int RST_CYCLES = 4;

  logic clk = 1'b0;
  logic por_n = 1'b0;
  logic timer_mode = 0, a0_sel_pin = 0, tl_sel_pin = 0, eoc_irq_en = 0;
  logic eoc_pulse = 0, ext_pin = 0, ext_rst = 0;
  logic a0_pend_set = 0, a0_pend_clr = 0, tl_pend_set = 0, tl_pend_clr = 0;
  logic wdr_flag_clr = 0;
  logic sys_rst_o, a0_req_o, tl_req_o, wdr_flag_o;

  int tests = 0, fails = 0;
  bit done = 0;

  always #2 clk = ~clk;

  irq_src_router #(.RST_CYCLES(RST_CYCLES)) u0 (
    .clk(clk), .por_n(por_n), .timer_mode(timer_mode),
    .a0_sel_pin(a0_sel_pin), .tl_sel_pin(tl_sel_pin),
    .eoc_irq_en(eoc_irq_en), .eoc_pulse(eoc_pulse),
    .ext_pin(ext_pin), .ext_rst(ext_rst),
    .a0_pend_set(a0_pend_set), .a0_pend_clr(a0_pend_clr),
    .tl_pend_set(tl_pend_set), .tl_pend_clr(tl_pend_clr),
    .wdr_flag_clr(wdr_flag_clr),
    .sys_rst_o(sys_rst_o), .a0_req_o(a0_req_o), .tl_req_o(tl_req_o),
    .wdr_flag_o(wdr_flag_o));

  task automatic chk(input string tag, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic clear_all();
    @(negedge clk);
    a0_pend_clr = 1; tl_pend_clr = 1; wdr_flag_clr = 1;
    @(negedge clk);
    a0_pend_clr = 0; tl_pend_clr = 0; wdr_flag_clr = 0;
  endtask

  // One-cycle count event; returns the number of reset-high cycles after it.
  task automatic eoc_and_measure(output int n);
    n = 0;
    @(negedge clk); eoc_pulse = 1;
    @(negedge clk); eoc_pulse = 0;
    for (int i = 0; i < 12; i++) begin
      if (sys_rst_o) n++;
      @(negedge clk);
    end
  endtask

  initial begin
    int n;
    idle(3);
    chk("R1 rst in por", sys_rst_o, 0);
    chk("R1 a0 in por", a0_req_o, 0);
    por_n = 1'b1;
    idle(2);
    chk("R1 rst", sys_rst_o, 0);
    chk("R1 a0", a0_req_o, 0);
    chk("R1 tl", tl_req_o, 0);
    chk("R1 flag", wdr_flag_o, 0);

    // Exhaustive sweep: mode, both selects, enable.
    for (int m = 0; m < 16; m++) begin
      logic tm, as, ts, en;
      tm = m[0]; as = m[1]; ts = m[2]; en = m[3];
      @(negedge clk);
      timer_mode = tm; a0_sel_pin = as; tl_sel_pin = ts; eoc_irq_en = en;
      clear_all();
      eoc_and_measure(n);
      chk(tm ? "R4 timer eoc no reset" : "R2 wdg reset length",
          n, tm ? 0 : RST_CYCLES);
      chk(tm ? "R6 a0 from eoc" : "R7 a0 no eoc in wdg",
          a0_req_o, int'(!as && tm && en));
      chk((!as && !ts) ? "R8 tie tl suppressed" : "R6 tl from eoc",
          tl_req_o, int'(!ts && tm && en && as));
      chk("R2 flag after eoc", wdr_flag_o, int'(!tm));
      clear_all();
      @(negedge clk); ext_pin = 1;
      idle(3);
      ext_pin = 0;
      idle(4);
      chk("R5 a0 from pin", a0_req_o, int'(as));
      chk("R5 tl from pin", tl_req_o, int'(ts));
      chk("R3 no pulse from pin", sys_rst_o, 0);
    end

    // R9: software set, clear, and set winning the tie.
    @(negedge clk);
    timer_mode = 0; a0_sel_pin = 0; tl_sel_pin = 0; eoc_irq_en = 0;
    clear_all();
    a0_pend_set = 1; tl_pend_set = 1;
    @(negedge clk); a0_pend_set = 0; tl_pend_set = 0;
    chk("R9 a0 sw set", a0_req_o, 1);
    chk("R9 tl sw set", tl_req_o, 1);
    a0_pend_clr = 1; tl_pend_clr = 1;
    @(negedge clk); a0_pend_clr = 0; tl_pend_clr = 0;
    chk("R9 a0 clr", a0_req_o, 0);
    chk("R9 tl clr", tl_req_o, 0);
    a0_pend_set = 1; a0_pend_clr = 1; tl_pend_set = 1; tl_pend_clr = 1;
    @(negedge clk);
    a0_pend_set = 0; a0_pend_clr = 0; tl_pend_set = 0; tl_pend_clr = 0;
    chk("R9 a0 set wins", a0_req_o, 1);
    chk("R9 tl set wins", tl_req_o, 1);

    // R10: sticky flag survives the pulse; set beats clear.
    clear_all();
    eoc_and_measure(n);
    chk("R10 flag after pulse", wdr_flag_o, 1);
    chk("R10 pulse over", sys_rst_o, 0);
    idle(2);
    eoc_pulse = 1; wdr_flag_clr = 1;
    @(negedge clk); eoc_pulse = 0; wdr_flag_clr = 0;
    chk("R10 set beats clr", wdr_flag_o, 1);
    idle(8);
    wdr_flag_clr = 1;
    @(negedge clk); wdr_flag_clr = 0;
    chk("R10 flag cleared", wdr_flag_o, 0);

    // R3: external reset edge, held high, both modes.
    for (int k = 0; k < 2; k++) begin
      @(negedge clk); timer_mode = k[0];
      clear_all();
      n = 0;
      ext_rst = 1;
      for (int i = 0; i < 16; i++) begin
        @(negedge clk);
        if (sys_rst_o) n++;
      end
      chk("R3 ext reset length", n, RST_CYCLES);
      chk("R3 ext reset no flag", wdr_flag_o, 0);
      ext_rst = 0;
      idle(4);
    end

    // R11: second trigger during a running pulse.
    @(negedge clk); timer_mode = 0;
    clear_all();
    n = 0;
    for (int i = 0; i < 14; i++) begin
      @(negedge clk);
      if (sys_rst_o) n++;
      eoc_pulse = (i == 0 || i == 2);
    end
    chk("R11 pulse not extended", n, RST_CYCLES);

    if (!done) begin
      done = 1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    #(4 * 150000);
    if (!done) begin
      done = 1;
      tests++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule